// File: doc/BRIEF.md
# Byte-Oriented SPI Master with Transmit and Receive Queues

This block is an SPI bus master that software drives through a small 32-bit register port. Two 8-bit queues, each 16 entries deep, sit between the register port and a bit shifter. One queue holds bytes waiting to go out. The other holds bytes captured from the slave. Software first programs how many bytes to send and how many to collect. It then loads some outgoing bytes and sets a run bit. From that point the shifter moves one byte per frame until both counts reach zero, and then it idles by itself.

Software chooses the clock polarity, the clock phase and the bit order. The serial clock runs at the system clock divided by a programmable value between 2 and 2047. The chip-select pin is a plain register bit that software sets and clears around a transaction.

The shifter waits instead of losing data. It holds the serial clock at its idle level when there is no outgoing byte to send, or when the receive queue has no room. Two sticky flags report that each count has run out. Software clears a flag by writing 1 to it.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, cs_n is 1 and sck is 0. The divider reads 2. The queue status word reads 0x0010_0000: both levels are 0, the receive-empty bit (bit 20) is 1 and the transmit-full bit (bit 4) is 0.
- R2: A write to word 4 pushes bits 7:0 into the transmit queue. A push into a full queue is dropped. The queue status word (word 9) shows the transmit level in bits 15:8 and transmit-full in bit 4.
- R3: A read of word 5 returns the oldest received byte and removes it from the queue. A read of word 5 while the queue is empty returns 0. The status word shows the receive level in bits 31:24 and receive-empty in bit 20.
- R4: In the control word (word 0), bit 0 is run. Writing 1 to bit 2 empties the transmit queue, and writing 1 to bit 3 empties the receive queue.
- R5: The divider (word 6) clamps written values into the range 2 to 2047. Within a byte, successive leading sck edges are exactly `divider` system clocks apart.
- R6: Word 1 bit 2 sets the sck idle level. With word 1 bit 1 clear, the slave samples mosi on the leading edge. With word 1 bit 1 set, mosi changes on the leading edge and is sampled on the trailing edge. miso is captured on the same edge that the slave samples on.
- R7: When word 1 bit 13 is clear, each byte is shifted most significant bit first. When it is set, each byte is shifted least significant bit first. The same order applies in both directions.
- R8: The transmit count (word 8) and the receive count (word 7) each drop by one per byte frame while they are nonzero. A frame with no outgoing byte owed sends 0x00. A frame with no incoming byte owed stores nothing. The shifter stops when both counts are zero.
- R9: Event word 2 bit 0 is set when the receive count reaches zero, and bit 2 is set when the transmit count reaches zero. Both bits hold until software writes 1 to them.
- R10: If a byte is still owed but the transmit queue is empty, no frame starts and sck stays at its idle level. The frame starts once a byte arrives.
- R11: If a byte is still owed to the receive side and the receive queue is full, no frame starts until software reads a byte. No received byte is lost.
- R12: Clearing run during a frame lets that frame finish. No further frame starts.
- R13: Word 3 bit 1 drives cs_n: writing 1 makes it 1 (inactive) and writing 0 makes it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after reg_rd |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Register reads return their data one clock after the read strobe. The bench drives strobes on falling edges and samples reg_rdata on the next falling edge. A byte frame takes one start cycle, eight times the divider in shifting cycles, and one finish cycle. Counts and flags change in the finish cycle. For that reason the bench never expects serial results at a fixed cycle. It polls the event word for completion, or waits a margin of several frames before it checks a stalled state. A monitor follows the sck edges directly. It collects mosi bits on the sampling edge of the selected mode, and it measures the gap between leading edges in system clocks. The bytes it collects are compared in order against a queue that the driver fills as it pushes bytes.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  // word indices of the register port
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 4'd1;
  localparam logic [ADDR_W-1:0] A_EVT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PIN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXD  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXD  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXC  = 4'd7;
  localparam logic [ADDR_W-1:0] A_TXC  = 4'd8;
  localparam logic [ADDR_W-1:0] A_FST  = 4'd9;

  // bit positions
  localparam int CTRL_RUN    = 0;
  localparam int CTRL_TXCLR  = 2;
  localparam int CTRL_RXCLR  = 3;
  localparam int CFG_PHASE   = 1;
  localparam int CFG_POL     = 2;
  localparam int CFG_LSB     = 13;
  localparam int EVT_RXDONE  = 0;
  localparam int EVT_TXDONE  = 2;
  localparam int PIN_CSN     = 1;
  localparam int FST_TXFULL  = 4;
  localparam int FST_TXLVL   = 8;
  localparam int FST_RXEMPTY = 20;
  localparam int FST_RXLVL   = 24;
  localparam int LVL_FIELD_W = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_FIN   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             lead,
  output logic             trail
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half  = div >> 1;
  assign lead  = en && (cnt == half - DIV_W'(1));
  assign trail = en && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (trail)  cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tx_pending,
  input  logic              rx_pending,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              lead,
  input  logic              trail,
  input  logic              miso,
  output logic              tick_en,
  output logic              tx_pop,
  output logic              rx_push,
  output logic              tx_dec,
  output logic              rx_dec,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi,
  output eng_state_e        state
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] tx_sr, rx_sr, load_val, rx_cap;
  logic [IDX_W-1:0]  bit_idx;
  logic              tx_owed, rx_owed, start;

  function automatic logic out_bit(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BYTE_W-1];
  endfunction

  function automatic logic [BYTE_W-1:0] advance(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  always_comb begin
    start    = (state == ENG_IDLE) && run && (tx_pending || rx_pending)
               && (!tx_pending || !tx_empty) && (!rx_pending || !rx_full);
    load_val = tx_pending ? tx_data : '0;
    rx_cap   = lsb_first ? {miso, rx_sr[BYTE_W-1:1]} : {rx_sr[BYTE_W-2:0], miso};
    tx_pop   = start && tx_pending;
    tick_en  = (state == ENG_SHIFT);
    rx_push  = (state == ENG_FIN) && rx_owed;
    rx_dec   = rx_push;
    tx_dec   = (state == ENG_FIN) && tx_owed;
    rx_byte  = rx_sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_idx <= '0;
      tx_owed <= 1'b0;
      rx_owed <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          sck <= cpol;
          if (start) begin
            state   <= ENG_SHIFT;
            bit_idx <= '0;
            tx_owed <= tx_pending;
            rx_owed <= rx_pending;
            if (!cpha) begin
              mosi  <= out_bit(load_val, lsb_first);
              tx_sr <= advance(load_val, lsb_first);
            end else begin
              tx_sr <= load_val;
            end
          end
        end
        ENG_SHIFT: begin
          if (lead) begin
            sck <= ~cpol;
            if (!cpha) begin
              rx_sr <= rx_cap;
            end else begin
              mosi  <= out_bit(tx_sr, lsb_first);
              tx_sr <= advance(tx_sr, lsb_first);
            end
          end
          if (trail) begin
            sck <= cpol;
            if (cpha) begin
              rx_sr <= rx_cap;
            end else begin
              mosi  <= out_bit(tx_sr, lsb_first);
              tx_sr <= advance(tx_sr, lsb_first);
            end
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == IDX_W'(BYTE_W-1)) state <= ENG_FIN;
          end
        end
        ENG_FIN: state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 11,
  parameter int DIV_MIN   = 2,
  localparam int DIV_MAX  = (1 << DIV_W) - 1,
  localparam int LVL_W    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic run_q, cpol_q, cpha_q, lsb_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] tx_left, rx_left;
  logic tx_done, rx_done;

  logic tx_push, tx_clr, rx_pop, rx_clr, tx_cnt_wr, rx_cnt_wr;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic eng_tx_pop, eng_rx_push, tx_dec, rx_dec, tick_en, lead, trail;
  eng_state_e state;
  logic [REG_W-1:0] rd_mux, fifo_stat;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [REG_W-1:0] v);
    if (v < REG_W'(DIV_MIN))      return DIV_W'(DIV_MIN);
    else if (v > REG_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else                          return v[DIV_W-1:0];
  endfunction

  always_comb begin
    tx_push   = reg_wr && (reg_addr == A_TXD);
    rx_pop    = reg_rd && (reg_addr == A_RXD);
    tx_clr    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_TXCLR];
    rx_clr    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_RXCLR];
    tx_cnt_wr = reg_wr && (reg_addr == A_TXC);
    rx_cnt_wr = reg_wr && (reg_addr == A_RXC);
  end

  spi_sync_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .wdata(reg_wdata[BYTE_W-1:0]),
    .pop(eng_tx_pop), .rdata(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  spi_sync_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(eng_rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .div(div_q),
    .lead(lead), .trail(trail)
  );

  spi_shift_engine u_eng (
    .clk(clk), .rst(rst), .run(run_q),
    .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q),
    .tx_pending(tx_left != '0), .rx_pending(rx_left != '0),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_data(tx_head),
    .lead(lead), .trail(trail), .miso(miso),
    .tick_en(tick_en), .tx_pop(eng_tx_pop), .rx_push(eng_rx_push),
    .tx_dec(tx_dec), .rx_dec(rx_dec), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .state(state)
  );

  // configuration, pin and count registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      cs_n    <= 1'b1;
      div_q   <= DIV_W'(DIV_MIN);
      tx_left <= '0;
      rx_left <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) run_q <= reg_wdata[CTRL_RUN];
      if (reg_wr && reg_addr == A_CFG) begin
        cpol_q <= reg_wdata[CFG_POL];
        cpha_q <= reg_wdata[CFG_PHASE];
        lsb_q  <= reg_wdata[CFG_LSB];
      end
      if (reg_wr && reg_addr == A_PIN) cs_n  <= reg_wdata[PIN_CSN];
      if (reg_wr && reg_addr == A_DIV) div_q <= clamp_div(reg_wdata);

      if (tx_cnt_wr)   tx_left <= CNT_W'(reg_wdata);
      else if (tx_dec) tx_left <= tx_left - 1'b1;
      if (rx_cnt_wr)   rx_left <= CNT_W'(reg_wdata);
      else if (rx_dec) rx_left <= rx_left - 1'b1;

      if (tx_dec && tx_left == CNT_W'(1))
        tx_done <= 1'b1;
      else if (reg_wr && reg_addr == A_EVT && reg_wdata[EVT_TXDONE])
        tx_done <= 1'b0;
      if (rx_dec && rx_left == CNT_W'(1))
        rx_done <= 1'b1;
      else if (reg_wr && reg_addr == A_EVT && reg_wdata[EVT_RXDONE])
        rx_done <= 1'b0;
    end
  end

  always_comb begin
    fifo_stat = '0;
    fifo_stat[FST_TXFULL]  = tx_full;
    fifo_stat[FST_RXEMPTY] = rx_empty;
    fifo_stat[FST_TXLVL +: LVL_FIELD_W] = LVL_FIELD_W'(tx_level);
    fifo_stat[FST_RXLVL +: LVL_FIELD_W] = LVL_FIELD_W'(rx_level);

    rd_mux = '0;
    case (reg_addr)
      A_CTRL: rd_mux[CTRL_RUN] = run_q;
      A_CFG: begin
        rd_mux[CFG_POL]   = cpol_q;
        rd_mux[CFG_PHASE] = cpha_q;
        rd_mux[CFG_LSB]   = lsb_q;
      end
      A_EVT: begin
        rd_mux[EVT_RXDONE] = rx_done;
        rd_mux[EVT_TXDONE] = tx_done;
      end
      A_PIN:   rd_mux[PIN_CSN] = cs_n;
      A_RXD:   rd_mux = rx_empty ? '0 : REG_W'(rx_head);
      A_DIV:   rd_mux = REG_W'(div_q);
      A_RXC:   rd_mux = REG_W'(rx_left);
      A_TXC:   rd_mux = REG_W'(tx_left);
      A_FST:   rd_mux = fifo_stat;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  parameter int DIV_W = 11,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              cs_n,
  input logic              sck,
  input logic              cpol_q,
  input eng_state_e        state,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              eng_tx_pop,
  input logic              eng_rx_push,
  input logic [DIV_W-1:0]  div_q,
  input logic              tx_dec,
  input logic              tx_cnt_wr,
  input logic [CNT_W-1:0]  tx_left,
  input logic              tx_done
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LVL_W'(DEPTH));

  p_rx_bound_r11: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(DEPTH));

  p_pop_needs_data_r10: assert property (@(posedge clk) disable iff (rst)
    eng_tx_pop |-> !tx_empty);

  p_push_needs_room_r11: assert property (@(posedge clk) disable iff (rst)
    eng_rx_push |-> !rx_full);

  p_div_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    (div_q >= DIV_W'(2)) && (div_q <= DIV_W'((1 << DIV_W) - 1)));

  p_cs_follows_r13: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_PIN) |=> (cs_n == $past(reg_wdata[PIN_CSN])));

  p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && $past(state) == ENG_IDLE && $stable(cpol_q)) |-> (sck == cpol_q));

  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_dec && !tx_cnt_wr) |=> (tx_left == $past(tx_left) - CNT_W'(1)));

  p_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_dec && !tx_cnt_wr && tx_left == CNT_W'(1)) |=> tx_done);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cs_n(cs_n), .sck(sck), .cpol_q(cpol_q), .state(state),
  .tx_level(tx_level), .rx_level(rx_level), .tx_empty(tx_empty), .rx_full(rx_full),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .div_q(div_q),
  .tx_dec(tx_dec), .tx_cnt_wr(tx_cnt_wr), .tx_left(tx_left), .tx_done(tx_done)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, miso, cs_n;

  // loopback slave answers with the inverted bit it sees
  assign miso = ~mosi;

  always #2 clk = ~clk;

  spi_fifo_master uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int errors = 0, checks = 0;
  int mon_err = 0, mon_checks = 0, per_err = 0, per_cnt = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  logic tb_cpol = 0, tb_cpha = 0;
  int   tb_div = 2;

  always @(negedge clk) cyc++;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial monitor: collects mosi on the sampling edge, times leading edges
  logic       last_sck = 1'b0;
  logic [7:0] mon_sr = '0;
  int mon_bits = 0, lead_idx = 0, last_lead = 0;
  always @(sck, cs_n) begin
    if (cs_n) begin
      mon_bits = 0; lead_idx = 0; last_sck = sck;
    end else if (sck !== last_sck) begin
      logic is_lead, is_samp;
      last_sck = sck;
      is_lead = (sck != tb_cpol);
      is_samp = tb_cpha ? !is_lead : is_lead;
      if (is_lead) begin
        if (lead_idx != 0) begin
          per_cnt++;
          if (cyc - last_lead != tb_div) per_err++;
        end
        last_lead = cyc;
        lead_idx = (lead_idx + 1) % 8;
      end
      if (is_samp) begin
        mon_sr = {mon_sr[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          mon_checks++;
          if (exp_q.size() == 0) begin
            mon_err++;
            $display("FAIL R6/R7: actual=%h expected=none (unexpected byte)", mon_sr);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (mon_sr !== e) begin
              mon_err++;
              $display("FAIL R6/R7: wire byte actual=%h expected=%h", mon_sr, e);
            end
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  // driver: pushes a byte and records what the wire and receive side must show
  task automatic push_byte(input logic [7:0] b, input bit lsb);
    bus_write(4'd4, {24'h0, b});
    exp_q.push_back(lsb ? rev8(b) : b);
    rx_q.push_back(~b);
  endtask

  task automatic drain_rx(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      logic [7:0] e;
      bus_read(4'd5, v);
      e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
      check(req, v, {24'h0, e});
    end
  endtask

  task automatic wait_events(input string req, input logic [31:0] mask);
    logic [31:0] v;
    int n = 0;
    do begin
      bus_read(4'd2, v);
      n++;
    end while (((v & mask) != mask) && n < 5000);
    check(req, v & mask, mask);
  endtask

  task automatic setup(input bit pol, input bit pha, input bit lsb, input int div);
    bus_write(4'd3, 32'h2);
    bus_write(4'd0, 32'h0);
    tb_cpol = pol; tb_cpha = pha; tb_div = div;
    bus_write(4'd1, (32'(pha) << 1) | (32'(pol) << 2) | (32'(lsb) << 13));
    bus_write(4'd6, 32'(div));
    bus_write(4'd0, 32'hC);
    bus_write(4'd2, 32'h5);
    exp_q.delete(); rx_q.delete();
    per_err = 0; per_cnt = 0;
  endtask

  task automatic xfer(input bit pol, input bit pha, input bit lsb, input int div,
                      input int n, input logic [7:0] base);
    setup(pol, pha, lsb, div);
    bus_write(4'd8, 32'(n));
    bus_write(4'd7, 32'(n));
    for (int i = 0; i < n; i++) push_byte(base + 8'(i * 37), lsb);
    bus_write(4'd3, 32'h0);
    bus_write(4'd0, 32'h1);
    wait_events("R9 completion flags", 32'h5);
    read_check("R9 both flags set", 4'd2, 32'h5);
    bus_write(4'd2, 32'h5);
    read_check("R9 write-one clears", 4'd2, 32'h0);
    read_check("R8 tx count exhausted", 4'd8, 32'h0);
    read_check("R8 rx count exhausted", 4'd7, 32'h0);
    drain_rx("R6/R7 received byte", n);
    check("R6/R7 all wire bytes seen", 32'(exp_q.size()), 32'h0);
    bus_write(4'd0, 32'h0);
    bus_write(4'd3, 32'h2);
  endtask

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n after reset", 32'(cs_n), 32'h1);
    check("R1 sck after reset", 32'(sck), 32'h0);
    read_check("R1 status word", 4'd9, 32'h0010_0000);
    read_check("R1 divider", 4'd6, 32'h2);

    // R13 chip select
    bus_write(4'd3, 32'h0);
    @(negedge clk);
    check("R13 cs_n low", 32'(cs_n), 32'h0);
    bus_write(4'd3, 32'h2);
    @(negedge clk);
    check("R13 cs_n high", 32'(cs_n), 32'h1);

    // R5 clamping
    bus_write(4'd6, 32'h0);
    read_check("R5 clamp low", 4'd6, 32'h2);
    bus_write(4'd6, 32'hFFFF);
    read_check("R5 clamp high", 4'd6, 32'h7FF);
    bus_write(4'd6, 32'h5);
    read_check("R5 in range", 4'd6, 32'h5);

    // R2 full queue drops, R4 clear
    for (int i = 0; i < 17; i++) bus_write(4'd4, 32'(i));
    read_check("R2 full status", 4'd9, 32'h0010_1010);
    bus_write(4'd0, 32'h4);
    read_check("R4 tx clear", 4'd9, 32'h0010_0000);

    // R3 empty pop
    read_check("R3 empty pop reads zero", 4'd5, 32'h0);

    // R6 R7 all modes, R5 period
    xfer(0, 0, 0, 2, 4, 8'hA5);
    check("R5 period div 2", 32'(per_err == 0 && per_cnt > 0), 32'h1);
    xfer(0, 1, 1, 5, 4, 8'h3C);
    check("R5 period div 5", 32'(per_err == 0 && per_cnt > 0), 32'h1);
    xfer(1, 0, 1, 3, 3, 8'h81);
    xfer(1, 1, 0, 4, 3, 8'h17);

    // R8 separate counts: one byte out, three in
    setup(0, 0, 0, 2);
    bus_write(4'd8, 32'h1);
    bus_write(4'd7, 32'h3);
    push_byte(8'hC3, 0);
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    rx_q.push_back(8'hFF); rx_q.push_back(8'hFF);
    bus_write(4'd3, 32'h0);
    bus_write(4'd0, 32'h1);
    wait_events("R8 uneven counts finish", 32'h5);
    drain_rx("R8 filler frames", 3);
    check("R8 three frames on wire", 32'(exp_q.size()), 32'h0);

    // R10 transmit starvation
    setup(1, 0, 0, 2);
    bus_write(4'd8, 32'h4);
    bus_write(4'd7, 32'h4);
    push_byte(8'h11, 0);
    push_byte(8'h22, 0);
    bus_write(4'd3, 32'h0);
    bus_write(4'd0, 32'h1);
    repeat (120) @(negedge clk);
    check("R10 sck idle while starved", 32'(sck), 32'h1);
    read_check("R10 tx count held", 4'd8, 32'h2);
    read_check("R10 no events yet", 4'd2, 32'h0);
    read_check("R10 two bytes received", 4'd9, 32'h0210_0000 & 32'hFF00_0000);
    push_byte(8'h33, 0);
    push_byte(8'h44, 0);
    wait_events("R10 resumes", 32'h5);
    drain_rx("R10 data", 4);

    // R11 receive queue full
    setup(0, 1, 0, 2);
    bus_write(4'd8, 32'd20);
    bus_write(4'd7, 32'd20);
    for (int i = 0; i < 16; i++) push_byte(8'(i * 13 + 5), 0);
    bus_write(4'd3, 32'h0);
    bus_write(4'd0, 32'h1);
    repeat (100) @(negedge clk);
    for (int i = 16; i < 20; i++) push_byte(8'(i * 13 + 5), 0);
    repeat (600) @(negedge clk);
    read_check("R11 stalled at full", 4'd9, 32'h1000_0400);
    read_check("R11 rx count held", 4'd7, 32'h4);
    drain_rx("R11 first sixteen", 16);
    wait_events("R11 resumes", 32'h5);
    drain_rx("R11 last four", 4);

    // R12 run cleared mid-frame
    setup(0, 0, 0, 40);
    bus_write(4'd8, 32'h3);
    bus_write(4'd7, 32'h3);
    push_byte(8'h5A, 0);
    push_byte(8'h6B, 0);
    push_byte(8'h7C, 0);
    bus_write(4'd3, 32'h0);
    bus_write(4'd0, 32'h1);
    repeat (40) @(negedge clk);
    bus_write(4'd0, 32'h0);
    repeat (800) @(negedge clk);
    read_check("R12 one frame finished", 4'd8, 32'h2);
    read_check("R12 queues after stop", 4'd9, 32'h0100_0200);
    drain_rx("R12 finished byte", 1);
    check("R12 sck idle", 32'(sck), 32'h0);
    bus_write(4'd3, 32'h2);
    exp_q.delete();

    done = 1;
    errors += mon_err;
    checks += mon_checks;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + mon_err + 1, checks + mon_checks + 1);
      $finish;
    end
  end
endmodule